// File: doc/BRIEF.md
# Fractional Pixel Clock Divider

This block derives a display pixel clock from a stream of reference enables. Two reference enables arrive at the block: one from the internal bus clock domain and one from an external display clock. A select bit in the control word picks which of them advances the divider. Each accepted enable counts as one input cycle. The divide ratio is a fixed-point number with an 8-bit integer part and a 4-bit fraction. The fraction is realised by accumulating it once per output period and lengthening a period by one input cycle whenever the accumulator wraps. Over many periods the average length then matches the programmed ratio.

Within each period the generated clock goes high at a programmable rise position and low at a programmable fall position. Both positions are given in half-cycle units and resolved to whole input cycles. The block also drives a one-cycle tick at every rising edge of the generated clock, for the downstream timing generators. It offers an output inversion as well. A new ratio or new edge positions take hold only at the next period boundary, so a running waveform never sees a truncated or stretched period.

Configuration uses a simple write port with three word addresses: ratio, edge positions and control.

Top module: `frac_pix_clk_div`

## Requirements
- R1: After reset the ratio register holds 0x10 (divide by 1.0), the edge word and the control word are 0, and pix_clk and pix_tick are low; the first accepted enable after reset starts a new output period.
- R2: The ratio word at address 0 carries the integer part in bits 11:4 and the fraction in bits 3:0. Each period lasts the integer part in input cycles, plus one cycle when adding the fraction to a 4-bit accumulator carries out.
- R3: An integer part of 0 is treated as 1, so the smallest period is one input cycle.
- R4: The edge word at address 1 carries the fall position in bits 24:16 and the rise position in bits 8:0, in half-cycle units. Bit 0 of each field is the half-cycle fraction and is dropped, so an edge acts at input cycle index field/2 counted from 0 at the period start.
- R5: When rise and fall fall on the same cycle, the rise wins; a position at or beyond the period length never acts.
- R6: Control bit 0 at address 2 selects the enable: 1 takes ref_ext_en and 0 takes ref_int_en; the other enable has no effect.
- R7: Control bit 1 inverts pix_clk at once; pix_tick is unaffected by it.
- R8: pix_tick is high for exactly one clock cycle, in the same cycle in which the uninverted generated clock turns from low to high.
- R9: A ratio or edge word written during a period takes effect only at the start of the next period.
- R10: In a cycle without an accepted enable, the position counter and the generated clock hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the configuration words |
| wr_addr | input | 2 | Word address: 0 ratio, 1 edge positions, 2 control |
| wr_data | input | 32 | Write data |
| ref_int_en | input | 1 | Input-cycle enable from the internal bus clock |
| ref_ext_en | input | 1 | Input-cycle enable from the external display clock |
| pix_clk | output | 1 | Generated pixel clock, optionally inverted |
| pix_tick | output | 1 | One-cycle pulse at each rising edge of the generated clock |

## Verification
Every cycle, the assertions check the following:
- the position counter stays below the current period length, and a period length is never zero;
- the counter and the clock level hold in cycles without an enable;
- the period length stays frozen until the period boundary;
- the tick is a single-cycle pulse that coincides with a high clock level.

Other behaviours need the bench's scenarios:
- the actual period sequence produced by a fraction;
- the truncation of the half-cycle edge bit;
- rise-over-fall priority and out-of-range edges;
- source selection and inversion.

The bench counts ticks, tick positions and high cycles over fixed windows and compares them with hand-derived values.

// File: rtl/pclk_div_pkg.sv
package pclk_div_pkg;

    typedef enum logic [1:0] {
        REG_RATIO = 2'd0,
        REG_EDGES = 2'd1,
        REG_CTRL  = 2'd2
    } pclk_reg_e;

    localparam int CTRL_SRC_BIT = 0;
    localparam int CTRL_INV_BIT = 1;

endpackage

// File: rtl/pclk_regs.sv
module pclk_regs
    import pclk_div_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int INT_W    = 8,
    parameter int FRAC_W   = 4,
    parameter int EDGE_W   = 9,
    parameter int FALL_LSB = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [1:0]              wr_addr,
    input  logic [DATA_W-1:0]       wr_data,
    output logic [INT_W+FRAC_W-1:0] ratio,
    output logic [EDGE_W-1:0]       rise_field,
    output logic [EDGE_W-1:0]       fall_field,
    output logic                    src_ext,
    output logic                    invert
);
    localparam int RATIO_W = INT_W + FRAC_W;
    localparam logic [RATIO_W-1:0] RATIO_RST = RATIO_W'(1) << FRAC_W;

    typedef struct packed {
        logic [RATIO_W-1:0] ratio;
        logic [EDGE_W-1:0]  rise;
        logic [EDGE_W-1:0]  fall;
        logic               src_ext;
        logic               invert;
    } regs_t;

    regs_t r_d, r_q;
    logic  unused_wr_bits;

    assign unused_wr_bits = ^wr_data;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (pclk_reg_e'(wr_addr))
                REG_RATIO: r_d.ratio = wr_data[RATIO_W-1:0];
                REG_EDGES: begin
                    r_d.rise = wr_data[EDGE_W-1:0];
                    r_d.fall = wr_data[FALL_LSB+EDGE_W-1:FALL_LSB];
                end
                REG_CTRL: begin
                    r_d.src_ext = wr_data[CTRL_SRC_BIT];
                    r_d.invert  = wr_data[CTRL_INV_BIT];
                end
                default: r_d = r_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.ratio   <= RATIO_RST;
            r_q.rise    <= '0;
            r_q.fall    <= '0;
            r_q.src_ext <= 1'b0;
            r_q.invert  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ratio      = r_q.ratio;
    assign rise_field = r_q.rise;
    assign fall_field = r_q.fall;
    assign src_ext    = r_q.src_ext;
    assign invert     = r_q.invert;

    // R1: the ratio word changes only through a ratio write
    a_r1_ratio_write_only: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == 2'd0) |=> $stable(ratio));

endmodule

// File: rtl/pclk_period_calc.sv
module pclk_period_calc #(
    parameter int INT_W  = 8,
    parameter int FRAC_W = 4
) (
    input  logic [INT_W+FRAC_W-1:0] ratio,
    input  logic [FRAC_W-1:0]       acc_in,
    output logic [FRAC_W-1:0]       acc_out,
    output logic [INT_W:0]          len_out
);
    localparam int LEN_W = INT_W + 1;

    logic [INT_W-1:0]  int_part;
    logic [INT_W-1:0]  int_clamped;
    logic [FRAC_W:0]   frac_sum;

    always_comb begin
        int_part    = ratio[INT_W+FRAC_W-1:FRAC_W];
        int_clamped = (int_part == '0) ? INT_W'(1) : int_part;
        frac_sum    = {1'b0, acc_in} + {1'b0, ratio[FRAC_W-1:0]};
        acc_out     = frac_sum[FRAC_W-1:0];
        len_out     = LEN_W'(int_clamped) + LEN_W'(frac_sum[FRAC_W]);
    end

    // R3: a period is never shorter than one input cycle
    always_comb begin
        a_r3_len_nonzero: assert (len_out != '0);
    end

endmodule

// File: rtl/pclk_wave.sv
module pclk_wave #(
    parameter int INT_W  = 8,
    parameter int FRAC_W = 4,
    parameter int EDGE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    adv,
    input  logic [INT_W+FRAC_W-1:0] ratio,
    input  logic [EDGE_W-1:0]       rise_field,
    input  logic [EDGE_W-1:0]       fall_field,
    output logic                    level,
    output logic                    tick
);
    localparam int LEN_W = INT_W + 1;
    localparam int POS_W = EDGE_W - 1;

    typedef struct packed {
        logic [LEN_W-1:0]  cnt;
        logic [LEN_W-1:0]  len;
        logic [FRAC_W-1:0] acc;
        logic [POS_W-1:0]  rise_pos;
        logic [POS_W-1:0]  fall_pos;
        logic              level;
        logic              tick;
    } wave_t;

    wave_t             w_d, w_q;
    logic [FRAC_W-1:0] acc_next;
    logic [LEN_W-1:0]  len_next;
    logic              period_end;
    logic              unused_half_bits;

    assign unused_half_bits = rise_field[0] ^ fall_field[0];

    pclk_period_calc #(
        .INT_W  (INT_W),
        .FRAC_W (FRAC_W)
    ) i_calc (
        .ratio   (ratio),
        .acc_in  (w_q.acc),
        .acc_out (acc_next),
        .len_out (len_next)
    );

    assign period_end = (w_q.cnt == w_q.len - LEN_W'(1));

    always_comb begin
        w_d      = w_q;
        w_d.tick = 1'b0;
        if (adv) begin
            if (period_end) begin
                w_d.cnt      = '0;
                w_d.len      = len_next;
                w_d.acc      = acc_next;
                w_d.rise_pos = rise_field[EDGE_W-1:1];
                w_d.fall_pos = fall_field[EDGE_W-1:1];
            end else begin
                w_d.cnt = w_q.cnt + LEN_W'(1);
            end
            if (w_d.cnt == LEN_W'(w_d.rise_pos)) begin
                w_d.level = 1'b1;
            end else if (w_d.cnt == LEN_W'(w_d.fall_pos)) begin
                w_d.level = 1'b0;
            end
            w_d.tick = w_d.level & ~w_q.level;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q.cnt      <= '0;
            w_q.len      <= LEN_W'(1);
            w_q.acc      <= '0;
            w_q.rise_pos <= '0;
            w_q.fall_pos <= '0;
            w_q.level    <= 1'b0;
            w_q.tick     <= 1'b0;
        end else begin
            w_q <= w_d;
        end
    end

    assign level = w_q.level;
    assign tick  = w_q.tick;

    // R2: position stays inside the running period
    a_r2_cnt_in_period: assert property (@(posedge clk) disable iff (!rst_n)
        w_q.cnt < w_q.len);

    // R8: tick lasts a single cycle
    a_r8_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R8: tick coincides with a high generated clock
    a_r8_tick_with_high: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> level);

    // R10: without an enable, position and level hold
    a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> ($stable(w_q.cnt) && $stable(level)));

    // R9: period length is frozen until the boundary
    a_r9_len_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !period_end) |=> $stable(w_q.len));

endmodule

// File: rtl/frac_pix_clk_div.sv
module frac_pix_clk_div #(
    parameter int DATA_W   = 32,
    parameter int INT_W    = 8,
    parameter int FRAC_W   = 4,
    parameter int EDGE_W   = 9,
    parameter int FALL_LSB = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ref_int_en,
    input  logic              ref_ext_en,
    output logic              pix_clk,
    output logic              pix_tick
);
    localparam int RATIO_W = INT_W + FRAC_W;

    logic [RATIO_W-1:0] ratio;
    logic [EDGE_W-1:0]  rise_field;
    logic [EDGE_W-1:0]  fall_field;
    logic               src_ext;
    logic               invert;
    logic               adv;
    logic               level;

    pclk_regs #(
        .DATA_W   (DATA_W),
        .INT_W    (INT_W),
        .FRAC_W   (FRAC_W),
        .EDGE_W   (EDGE_W),
        .FALL_LSB (FALL_LSB)
    ) i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .ratio      (ratio),
        .rise_field (rise_field),
        .fall_field (fall_field),
        .src_ext    (src_ext),
        .invert     (invert)
    );

    assign adv = src_ext ? ref_ext_en : ref_int_en;

    pclk_wave #(
        .INT_W  (INT_W),
        .FRAC_W (FRAC_W),
        .EDGE_W (EDGE_W)
    ) i_wave (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv        (adv),
        .ratio      (ratio),
        .rise_field (rise_field),
        .fall_field (fall_field),
        .level      (level),
        .tick       (pix_tick)
    );

    assign pix_clk = level ^ invert;

    // R6: with both enables low the output clock cannot move
    a_r6_no_enable_no_move: assert property (@(posedge clk) disable iff (!rst_n)
        (!ref_int_en && !ref_ext_en) |=> $stable(level));

endmodule

// File: tb/test_frac_pix_clk_div.sv
module test_frac_pix_clk_div;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        ref_int_en = 1'b0;
    logic        ref_ext_en = 1'b0;
    logic        pix_clk;
    logic        pix_tick;

    int total = 0;
    int bad = 0;
    int n_tick, tick_sum, n_high;

    always #4 clk = ~clk;

    frac_pix_clk_div i_frac_pix_clk_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .ref_int_en (ref_int_en),
        .ref_ext_en (ref_ext_en),
        .pix_clk    (pix_clk),
        .pix_tick   (pix_tick)
    );

    localparam int NV = 7;
    localparam logic [31:0] V_RATIO [NV] = '{32'h20, 32'h28, 32'h34, 32'h08, 32'h40, 32'h30, 32'h30};
    localparam logic [31:0] V_EDGE  [NV] = '{32'h0002_0000, 32'h0002_0000, 32'h0003_0000,
                                             32'h0002_0000, 32'h0007_0003, 32'h000A_0000,
                                             32'h0002_0002};
    localparam int V_N    [NV] = '{12, 10, 13, 6, 8, 9, 6};
    localparam int V_TICK [NV] = '{6, 4, 4, 2, 2, 1, 1};
    localparam int V_TSUM [NV] = '{30, 14, 18, 3, 6, 0, 1};
    localparam int V_HIGH [NV] = '{6, 4, 4, 4, 4, 9, 5};

    function automatic string vec_tag(int i);
        case (i)
            0, 1, 2: return "R2";
            3:       return "R3";
            4:       return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check(string tag, string what, int got, int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // drives the chosen enables for n cycles; counts ticks, tick index sum and high pix_clk
    task automatic run(int n, logic use_int, logic use_ext);
        n_tick = 0;
        tick_sum = 0;
        n_high = 0;
        for (int i = 0; i < n; i++) begin
            ref_int_en = use_int;
            ref_ext_en = use_ext;
            @(negedge clk);
            if (pix_tick) begin
                n_tick++;
                tick_sum += i;
            end
            if (pix_clk) n_high++;
        end
        ref_int_en = 1'b0;
        ref_ext_en = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        total++;
        $display("FAIL R8 watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // table of ratio/edge vectors, each from a fresh reset
        for (int v = 0; v < NV; v++) begin
            do_reset();
            wr(2'd0, V_RATIO[v]);
            wr(2'd1, V_EDGE[v]);
            run(V_N[v], 1'b1, 1'b0);
            check(vec_tag(v), "tick count", n_tick, V_TICK[v]);
            check(vec_tag(v), "tick positions", tick_sum, V_TSUM[v]);
            check(vec_tag(v), "high cycles", n_high, V_HIGH[v]);
        end

        // R1: reset state and default divide-by-one
        do_reset();
        check("R1", "pix_clk after reset", int'(pix_clk), 0);
        check("R1", "pix_tick after reset", int'(pix_tick), 0);
        run(5, 1'b1, 1'b0);
        check("R1", "default ticks", n_tick, 1);
        check("R1", "default high", n_high, 5);

        // R6 / R10: source selection, unselected enable ignored
        do_reset();
        wr(2'd0, 32'h20);
        wr(2'd1, 32'h0002_0000);
        run(6, 1'b0, 1'b1);
        check("R6", "ext ignored when int selected ticks", n_tick, 0);
        check("R6", "ext ignored when int selected high", n_high, 0);
        wr(2'd2, 32'h1);
        run(6, 1'b1, 1'b0);
        check("R10", "int ignored when ext selected ticks", n_tick, 0);
        check("R10", "int ignored when ext selected high", n_high, 0);
        run(6, 1'b0, 1'b1);
        check("R6", "ext selected ticks", n_tick, 3);
        check("R6", "ext selected tick positions", tick_sum, 6);

        // R7: inversion is immediate and leaves the tick alone
        do_reset();
        wr(2'd0, 32'h40);
        wr(2'd1, 32'h0002_0000);
        wr(2'd2, 32'h2);
        check("R7", "inverted idle level", int'(pix_clk), 1);
        run(8, 1'b1, 1'b0);
        check("R7", "inverted high cycles", n_high, 6);
        check("R7", "ticks under inversion", n_tick, 2);
        check("R8", "tick positions under inversion", tick_sum, 4);

        // R9: mid-period rewrite waits for the boundary
        do_reset();
        wr(2'd0, 32'h40);
        wr(2'd1, 32'h0004_0000);
        run(2, 1'b1, 1'b0);
        check("R9", "first period start tick", n_tick, 1);
        wr(2'd0, 32'h20);
        wr(2'd1, 32'h0002_0000);
        run(6, 1'b1, 1'b0);
        check("R9", "ticks after rewrite", n_tick, 2);
        check("R9", "tick positions after rewrite", tick_sum, 6);
        check("R9", "high after rewrite", n_high, 2);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule